// File: doc/BRIEF.md
# Two-Page Dual-Port Scratch RAM

This block is an on-chip scratch memory with two independent read/write ports. One port serves an internal system bus and the other a local processor bus. Each port checks whether its address falls inside a 128 KB memory window, which the block recognises in two address-space aliases: an unmapped-cached view and an uncached view. Both aliases reach the same storage. Byte, halfword and word reads and writes are supported on either port.

The storage is built from two single-port pages. Bit 16 of the window offset chooses the page. Requests from the two ports to different pages run in the same cycle. When both ports want the same page in the same cycle, a two-state arbiter decides which one goes.

- In state `ARB_I_FIRST`, the internal port wins and the local port sees `l_wait`. The arbiter then moves to `ARB_L_TURN`.
- In state `ARB_L_TURN`, the local port wins any same-page conflict and the arbiter returns to `ARB_I_FIRST` after exactly one cycle. It also stays in `ARB_I_FIRST` whenever no conflict arises there.

A stalled requester holds its request until `*_wait` drops. Every accepted request is answered one cycle later by `*_ready`. The words per page are set by `PAGE_WORDS`, a power of two up to 16384, and may be made small for simulation.

Top module: `dpage_ram`

## Requirements
- R1: During reset and in the first cycle after it, with no requests, `*_ready`, `*_err` and `*_wait` are 0 and `*_rdata` is 0 on both ports. The arbiter leaves reset in `ARB_I_FIRST`, so the first same-page conflict goes to the internal port.
- R2: An address hits when two conditions hold. Bits [31:29] must be 3'b000 or 3'b101, and bits [28:0] must lie in 0x055F0000..0x0560FFFF. An address in either alias reaches the same byte as the matching address in the other alias. The first and last words of the window are reachable.
- R3: A request whose address misses the window is taken off the bus at once. It gives no wait, no ready one cycle later, and no change to any stored byte.
- R4: `*_size` is encoded as 2'b00 byte, 2'b01 halfword, 2'b10 word and 2'b11 invalid. A halfword with address bit 0 set, a word with address bits [1:0] not 00, or size 2'b11 is an error. An error request inside the window is accepted without waiting. It returns `*_ready`=1 with `*_err`=1 and `*_rdata`=0 one cycle later and writes nothing.
- R5: Window offset bit 16 selects the page: 0 for page 0, 1 for page 1. Valid requests from the two ports to different pages in the same cycle are both accepted with no wait.
- R6: When both ports make valid requests to the same page in the same cycle, the winner is set by the arbiter state. In `ARB_I_FIRST` the internal port is served and `l_wait`=1 for that cycle. In `ARB_L_TURN` the local port is served and `i_wait`=1. The local port never waits two cycles in a row.
- R7: A request that is accepted in cycle t, read or write, gives `*_ready`=1 with `*_err`=0 in cycle t+1 only.
- R8: Byte lanes are little-endian: the byte at address bits [1:0]=k is word bits [8k+7:8k]. Byte and halfword reads return right-justified, zero-extended data. Byte and halfword writes take their data from the low bits of `*_wdata` and change only the addressed lanes. `*_rdata` is 0 on write responses and whenever `*_ready` is 0.
- R9: Within a page, the word index is window offset bits [log2(PAGE_WORDS)+1:2]. Offset bits above that index and below bit 16 are ignored, so storage repeats every PAGE_WORDS*4 bytes inside a page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_req | input | 1 | Internal port request, held while `i_wait` is 1 |
| i_we | input | 1 | Internal port write (1) or read (0) |
| i_size | input | 2 | Internal port access size code |
| i_addr | input | 32 | Internal port byte address |
| i_wdata | input | 32 | Internal port write data, low bits for narrow writes |
| i_wait | output | 1 | Internal port request stalled this cycle |
| i_ready | output | 1 | Internal port response for the request accepted last cycle |
| i_err | output | 1 | Internal port response is an error |
| i_rdata | output | 32 | Internal port read data |
| l_req | input | 1 | Local port request, held while `l_wait` is 1 |
| l_we | input | 1 | Local port write (1) or read (0) |
| l_size | input | 2 | Local port access size code |
| l_addr | input | 32 | Local port byte address |
| l_wdata | input | 32 | Local port write data, low bits for narrow writes |
| l_wait | output | 1 | Local port request stalled this cycle |
| l_ready | output | 1 | Local port response for the request accepted last cycle |
| l_err | output | 1 | Local port response is an error |
| l_rdata | output | 32 | Local port read data |

## Verification
The wait outputs are combinational, so they belong to the cycle in which a request is presented. The bench drives each request at a falling edge and compares `*_wait` one time step later, in that same cycle. Ready, error and read data are due exactly one rising edge after the accepting cycle: one edge registers the bank read and the response flags. The bench's queue-based model therefore holds each expected response for one step and compares it at the following falling edge, and it expects all-zero outputs in every other cycle. Conflicts are resolved by the model's own fairness bit, so alternating same-page traffic, the first conflict after reset and the miss and error cases are all checked without reference to the design's state.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    // Window start inside the 512 MB region selected by address bits [28:0]
    localparam logic [28:0] WIN_BASE  = 29'h055F0000;
    localparam int          WIN_BYTES = 131072;

    // Address-space codes in bits [31:29] that alias onto the window
    localparam logic [2:0]  SPACE_CACHED   = 3'b000;
    localparam logic [2:0]  SPACE_UNCACHED = 3'b101;

    localparam int PORT_I = 0;
    localparam int PORT_L = 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } size_e;

    typedef enum logic {
        ARB_I_FIRST = 1'b0,
        ARB_L_TURN  = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic        want;    // in window, well formed: needs a bank
        logic        fault;   // in window, malformed: error response
        logic        write;
        logic        page;
        logic [1:0]  lo;
        logic [3:0]  lanes;
        logic [31:0] wdata;
        size_e       size;
    } dec_t;

endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode
    import dpr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          req,
    input  logic          we,
    input  logic [1:0]    size,
    input  logic [31:0]   addr,
    input  logic [31:0]   wdata,
    output dec_t          dec,
    output logic [AW-1:0] idx
);

    logic        space_ok;
    logic        range_ok;
    logic        hit;
    logic        aligned;
    logic [28:0] rel;
    size_e       sz;

    always_comb begin
        sz       = size_e'(size);
        space_ok = (addr[31:29] == SPACE_CACHED) || (addr[31:29] == SPACE_UNCACHED);
        rel      = addr[28:0] - WIN_BASE;
        range_ok = (addr[28:0] >= WIN_BASE) && (rel < 29'(WIN_BYTES));
        hit      = req && space_ok && range_ok;
    end

    always_comb begin
        unique case (sz)
            SZ_BYTE: begin
                aligned   = 1'b1;
                dec.lanes = 4'b0001 << addr[1:0];
                dec.wdata = {4{wdata[7:0]}};
            end
            SZ_HALF: begin
                aligned   = !addr[0];
                dec.lanes = addr[1] ? 4'b1100 : 4'b0011;
                dec.wdata = {2{wdata[15:0]}};
            end
            SZ_WORD: begin
                aligned   = (addr[1:0] == 2'b00);
                dec.lanes = 4'b1111;
                dec.wdata = wdata;
            end
            SZ_BAD: begin
                aligned   = 1'b0;
                dec.lanes = 4'b0000;
                dec.wdata = wdata;
            end
        endcase
        dec.want  = hit && aligned;
        dec.fault = hit && !aligned;
        dec.write = we;
        dec.page  = rel[16];
        dec.lo    = addr[1:0];
        dec.size  = sz;
        idx       = rel[AW+1:2];
    end

endmodule

// File: rtl/dpr_bank.sv
module dpr_bank #(
    parameter  int WORDS = 256,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [3:0]    be,
    input  logic [AW-1:0] idx,
    input  logic [31:0]   wd,
    output logic [31:0]   rd
);

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] store [WORDS];
        logic [7:0] lane_q;

        always_ff @(posedge clk) begin
            if (en) begin
                if (we) begin
                    if (be[g]) begin
                        store[idx] <= wd[8*g +: 8];
                    end
                end else begin
                    lane_q <= store[idx];
                end
            end
        end

        assign rd[8*g +: 8] = lane_q;
    end

endmodule

// File: rtl/dpr_page_arb.sv
module dpr_page_arb
    import dpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       i_want,
    input  logic       i_page,
    input  logic       l_want,
    input  logic       l_page,
    output logic       i_go,
    output logic       l_go,
    output logic       i_wait,
    output logic       l_wait,
    output logic [1:0] bank_en,
    output logic [1:0] bank_by_i
);

    arb_state_e state_q;
    arb_state_e state_d;
    logic       clash;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_I_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // Grants, stalls and next state
    always_comb begin
        clash = i_want && l_want && (i_page == l_page);
        unique case (state_q)
            ARB_I_FIRST: begin
                i_go    = i_want;
                l_go    = l_want && !clash;
                state_d = clash ? ARB_L_TURN : ARB_I_FIRST;
            end
            ARB_L_TURN: begin
                l_go    = l_want;
                i_go    = i_want && !clash;
                state_d = ARB_I_FIRST;
            end
        endcase
        i_wait = i_want && !i_go;
        l_wait = l_want && !l_go;
        for (int g = 0; g < 2; g++) begin
            bank_by_i[g] = i_go && (i_page == 1'(g));
            bank_en[g]   = bank_by_i[g] || (l_go && (l_page == 1'(g)));
        end
    end

    // R6: a page is never handed to both ports in one cycle
    p_single_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(i_go && l_go && (i_page == l_page)));

    // R6: the local port is stalled for at most one cycle at a time
    p_l_wait_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        l_wait |=> !l_wait);

    // R6: the internal port only yields right after the local port yielded
    p_i_wait_after_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
        i_wait |-> $past(l_wait));

    // R5: different pages never stall
    p_split_pages_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (i_want && l_want && (i_page != l_page)) |-> (!i_wait && !l_wait));

endmodule

// File: rtl/dpr_rsp.sv
module dpr_rsp
    import dpr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  logic        fault,
    input  logic        write,
    input  logic        page,
    input  size_e       size,
    input  logic [1:0]  lo,
    input  logic [31:0] bank0_rd,
    input  logic [31:0] bank1_rd,
    output logic        ready,
    output logic        err,
    output logic [31:0] rdata
);

    logic        v_q;
    logic        e_q;
    logic        rd_q;
    logic        pg_q;
    size_e       sz_q;
    logic [1:0]  lo_q;
    logic [31:0] word;
    logic [31:0] shifted;
    logic [31:0] shaped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q  <= 1'b0;
            e_q  <= 1'b0;
            rd_q <= 1'b0;
            pg_q <= 1'b0;
            sz_q <= SZ_WORD;
            lo_q <= 2'b00;
        end else begin
            v_q  <= accept;
            e_q  <= accept && fault;
            rd_q <= accept && !write;
            pg_q <= page;
            sz_q <= size;
            lo_q <= lo;
        end
    end

    always_comb begin
        word    = pg_q ? bank1_rd : bank0_rd;
        shifted = word >> {lo_q, 3'b000};
        unique case (sz_q)
            SZ_BYTE: shaped = {24'h0, shifted[7:0]};
            SZ_HALF: shaped = {16'h0, shifted[15:0]};
            SZ_WORD: shaped = word;
            SZ_BAD:  shaped = 32'h0;
        endcase
        ready = v_q;
        err   = v_q && e_q;
        rdata = (v_q && rd_q && !e_q) ? shaped : 32'h0;
    end

    // R4: an error response always stems from a malformed request
    p_err_from_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(fault && accept));

endmodule

// File: rtl/dpage_ram.sv
module dpage_ram
    import dpr_pkg::*;
#(
    parameter int PAGE_WORDS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        i_req,
    input  logic        i_we,
    input  logic [1:0]  i_size,
    input  logic [31:0] i_addr,
    input  logic [31:0] i_wdata,
    output logic        i_wait,
    output logic        i_ready,
    output logic        i_err,
    output logic [31:0] i_rdata,
    input  logic        l_req,
    input  logic        l_we,
    input  logic [1:0]  l_size,
    input  logic [31:0] l_addr,
    input  logic [31:0] l_wdata,
    output logic        l_wait,
    output logic        l_ready,
    output logic        l_err,
    output logic [31:0] l_rdata
);

    localparam int AW = $clog2(PAGE_WORDS);

    logic        req_v   [2];
    logic        we_v    [2];
    logic [1:0]  size_v  [2];
    logic [31:0] addr_v  [2];
    logic [31:0] wdata_v [2];
    dec_t        dec     [2];
    logic [AW-1:0] idx   [2];
    logic        go      [2];
    logic        wait_v  [2];
    logic        accept  [2];
    logic        ready_v [2];
    logic        err_v   [2];
    logic [31:0] rdata_v [2];
    logic [31:0] bank_rd [2];
    logic [1:0]  bank_en;
    logic [1:0]  bank_by_i;

    always_comb begin
        req_v[PORT_I]   = i_req;
        we_v[PORT_I]    = i_we;
        size_v[PORT_I]  = i_size;
        addr_v[PORT_I]  = i_addr;
        wdata_v[PORT_I] = i_wdata;
        req_v[PORT_L]   = l_req;
        we_v[PORT_L]    = l_we;
        size_v[PORT_L]  = l_size;
        addr_v[PORT_L]  = l_addr;
        wdata_v[PORT_L] = l_wdata;
        i_wait  = wait_v[PORT_I];
        i_ready = ready_v[PORT_I];
        i_err   = err_v[PORT_I];
        i_rdata = rdata_v[PORT_I];
        l_wait  = wait_v[PORT_L];
        l_ready = ready_v[PORT_L];
        l_err   = err_v[PORT_L];
        l_rdata = rdata_v[PORT_L];
    end

    dpr_page_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .i_want    (dec[PORT_I].want),
        .i_page    (dec[PORT_I].page),
        .l_want    (dec[PORT_L].want),
        .l_page    (dec[PORT_L].page),
        .i_go      (go[PORT_I]),
        .l_go      (go[PORT_L]),
        .i_wait    (wait_v[PORT_I]),
        .l_wait    (wait_v[PORT_L]),
        .bank_en   (bank_en),
        .bank_by_i (bank_by_i)
    );

    for (genvar p = 0; p < 2; p++) begin : g_port
        dpr_port_decode #(.AW(AW)) u_dec (
            .req   (req_v[p]),
            .we    (we_v[p]),
            .size  (size_v[p]),
            .addr  (addr_v[p]),
            .wdata (wdata_v[p]),
            .dec   (dec[p]),
            .idx   (idx[p])
        );

        assign accept[p] = go[p] || dec[p].fault;

        dpr_rsp u_rsp (
            .clk      (clk),
            .rst_n    (rst_n),
            .accept   (accept[p]),
            .fault    (dec[p].fault),
            .write    (dec[p].write),
            .page     (dec[p].page),
            .size     (dec[p].size),
            .lo       (dec[p].lo),
            .bank0_rd (bank_rd[0]),
            .bank1_rd (bank_rd[1]),
            .ready    (ready_v[p]),
            .err      (err_v[p]),
            .rdata    (rdata_v[p])
        );

        // R7: a response only follows an accepted request
        p_ready_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ready_v[p] |-> $past(accept[p]));

        // R3: a window miss never stalls
        p_miss_no_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (req_v[p] && !dec[p].want && !dec[p].fault) |-> !wait_v[p]);

        // R3: a window miss is never answered
        p_miss_no_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (req_v[p] && !dec[p].want && !dec[p].fault) |=> !ready_v[p]);
    end

    for (genvar g = 0; g < 2; g++) begin : g_page
        logic          src;
        logic [AW-1:0] b_idx;
        logic          b_we;
        logic [3:0]    b_be;
        logic [31:0]   b_wd;

        always_comb begin
            src   = !bank_by_i[g];
            b_idx = idx[src];
            b_we  = dec[src].write;
            b_be  = dec[src].lanes;
            b_wd  = dec[src].wdata;
        end

        dpr_bank #(.WORDS(PAGE_WORDS)) u_bank (
            .clk (clk),
            .en  (bank_en[g]),
            .we  (b_we),
            .be  (b_be),
            .idx (b_idx),
            .wd  (b_wd),
            .rd  (bank_rd[g])
        );

        // R4: malformed requests never reach a bank
        p_fault_no_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (dec[PORT_I].fault && dec[PORT_L].fault) |-> !bank_en[g]);
    end

endmodule

// File: tb/dpage_ram_tb.sv
module dpage_ram_tb;

    localparam int PW = 256;
    localparam int PB = PW * 4;
    localparam logic [31:0] W0 = 32'h055F0000;  // cached alias
    localparam logic [31:0] W2 = 32'hA55F0000;  // uncached alias
    localparam logic [31:0] PG1 = 32'h00010000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        i_req, i_we, l_req, l_we;
    logic [1:0]  i_size, l_size;
    logic [31:0] i_addr, i_wdata, l_addr, l_wdata;
    logic        i_wait, i_ready, i_err, l_wait, l_ready, l_err;
    logic [31:0] i_rdata, l_rdata;

    dpage_ram #(.PAGE_WORDS(PW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .i_req(i_req), .i_we(i_we), .i_size(i_size), .i_addr(i_addr), .i_wdata(i_wdata),
        .i_wait(i_wait), .i_ready(i_ready), .i_err(i_err), .i_rdata(i_rdata),
        .l_req(l_req), .l_we(l_we), .l_size(l_size), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_wait(l_wait), .l_ready(l_ready), .l_err(l_err), .l_rdata(l_rdata)
    );

    typedef struct {
        bit        we;
        bit [1:0]  sz;
        bit [31:0] a;
        bit [31:0] d;
        string     tag;
    } req_t;

    req_t        qi[$];
    req_t        ql[$];
    logic [7:0]  mem [int];
    int          checks = 0;
    int          errors = 0;
    bit          owed = 1'b0;
    bit          pv [2];
    bit          pe [2];
    logic [31:0] pd [2];
    string       ptag [2];

    function automatic bit m_hit(bit [31:0] a);
        return ((a[31:29] == 3'b000) || (a[31:29] == 3'b101)) &&
               (a[28:0] >= 29'h055F0000) && (a[28:0] <= 29'h0560FFFF);
    endfunction

    function automatic bit m_ok(bit [1:0] sz, bit [31:0] a);
        case (sz)
            2'd0:    return 1'b1;
            2'd1:    return !a[0];
            2'd2:    return a[1:0] == 2'b00;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit m_page(bit [31:0] a);
        bit [28:0] off = a[28:0] - 29'h055F0000;
        return off[16];
    endfunction

    function automatic int m_key(bit [31:0] a);
        bit [28:0] off = a[28:0] - 29'h055F0000;
        return (off[16] ? PB : 0) + (int'(off[15:0]) % PB);
    endfunction

    function automatic logic [31:0] m_read(bit [1:0] sz, bit [31:0] a);
        int k = m_key(a);
        case (sz)
            2'd0:    return {24'h0, mem[k]};
            2'd1:    return {16'h0, mem[k+1], mem[k]};
            default: return {mem[k+3], mem[k+2], mem[k+1], mem[k]};
        endcase
    endfunction

    task automatic m_write(bit [1:0] sz, bit [31:0] a, bit [31:0] d);
        int k = m_key(a);
        mem[k] = d[7:0];
        if (sz != 2'd0) mem[k+1] = d[15:8];
        if (sz == 2'd2) begin
            mem[k+2] = d[23:16];
            mem[k+3] = d[31:24];
        end
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic pi(bit we, bit [1:0] sz, bit [31:0] a, bit [31:0] d, string tag);
        req_t r;
        r.we = we; r.sz = sz; r.a = a; r.d = d; r.tag = tag;
        qi.push_back(r);
    endtask

    task automatic pl(bit we, bit [1:0] sz, bit [31:0] a, bit [31:0] d, string tag);
        req_t r;
        r.we = we; r.sz = sz; r.a = a; r.d = d; r.tag = tag;
        ql.push_back(r);
    endtask

    // One clock of stimulus, comparison and model update
    task automatic step();
        req_t ri, rl;
        bit hi, hl, wi, wl, conf, gi, gl, fi, fl;
        @(negedge clk);
        hi = (qi.size() != 0);
        hl = (ql.size() != 0);
        ri.we = 0; ri.sz = 0; ri.a = 0; ri.d = 0; ri.tag = "R7";
        rl = ri;
        if (hi) ri = qi[0];
        if (hl) rl = ql[0];
        i_req = hi; i_we = ri.we; i_size = ri.sz; i_addr = ri.a; i_wdata = ri.d;
        l_req = hl; l_we = rl.we; l_size = rl.sz; l_addr = rl.a; l_wdata = rl.d;
        #1;
        // responses due for the previous cycle (R7, R4, R8)
        chk(ptag[0], "i_ready R7", {31'b0, i_ready}, {31'b0, pv[0]});
        chk(ptag[0], "i_err R4",   {31'b0, i_err},   {31'b0, pe[0]});
        chk(ptag[0], "i_rdata R8", i_rdata, pd[0]);
        chk(ptag[1], "l_ready R7", {31'b0, l_ready}, {31'b0, pv[1]});
        chk(ptag[1], "l_err R4",   {31'b0, l_err},   {31'b0, pe[1]});
        chk(ptag[1], "l_rdata R8", l_rdata, pd[1]);
        // arbitration for this cycle (R5, R6)
        wi   = hi && m_hit(ri.a) && m_ok(ri.sz, ri.a);
        wl   = hl && m_hit(rl.a) && m_ok(rl.sz, rl.a);
        fi   = hi && m_hit(ri.a) && !m_ok(ri.sz, ri.a);
        fl   = hl && m_hit(rl.a) && !m_ok(rl.sz, rl.a);
        conf = wi && wl && (m_page(ri.a) == m_page(rl.a));
        gi   = wi && !(conf && owed);
        gl   = wl && !(conf && !owed);
        chk(ri.tag, "i_wait R6", {31'b0, i_wait}, {31'b0, wi && !gi});
        chk(rl.tag, "l_wait R6", {31'b0, l_wait}, {31'b0, wl && !gl});
        owed = conf && !owed;
        // expected responses for next cycle
        pv[0] = fi || gi; pe[0] = fi;
        pd[0] = (gi && !ri.we) ? m_read(ri.sz, ri.a) : 32'h0;
        pv[1] = fl || gl; pe[1] = fl;
        pd[1] = (gl && !rl.we) ? m_read(rl.sz, rl.a) : 32'h0;
        ptag[0] = ri.tag;
        ptag[1] = rl.tag;
        if (gi && ri.we) m_write(ri.sz, ri.a, ri.d);
        if (gl && rl.we) m_write(rl.sz, rl.a, rl.d);
        if (hi && (!wi || gi)) void'(qi.pop_front());
        if (hl && (!wl || gl)) void'(ql.pop_front());
    endtask

    task automatic run();
        while (qi.size() != 0 || ql.size() != 0) step();
        step();
        step();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            pv[p] = 0; pe[p] = 0; pd[p] = 0; ptag[p] = "R1";
        end
        rst_n = 1'b0;
        i_req = 0; i_we = 0; i_size = 0; i_addr = 0; i_wdata = 0;
        l_req = 0; l_we = 0; l_size = 0; l_addr = 0; l_wdata = 0;
        repeat (3) @(negedge clk);
        // R1: quiet outputs while in reset
        chk("R1", "i_ready", {31'b0, i_ready}, 32'h0);
        chk("R1", "l_ready", {31'b0, l_ready}, 32'h0);
        chk("R1", "i_rdata", i_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: quiet outputs in the first cycle after reset
        chk("R1", "i_wait", {31'b0, i_wait}, 32'h0);
        chk("R1", "l_wait", {31'b0, l_wait}, 32'h0);
        chk("R1", "i_err",  {31'b0, i_err},  32'h0);
        chk("R1", "l_err",  {31'b0, l_err},  32'h0);
        chk("R1", "l_rdata", l_rdata, 32'h0);

        // R1: first same-page conflict after reset goes to the internal port
        pi(1, 2'd2, W0 + 32'h0FC, 32'hC0DE0001, "R1");
        pl(1, 2'd2, W0 + 32'h0F8, 32'hC0DE0002, "R1");
        run();

        // R5: page 0 and page 1 filled in parallel, no stalls
        for (int k = 0; k < 16; k++) begin
            pi(1, 2'd2, W0 + 32'(4*k),       32'h10000000 + 32'(k) * 32'h01010101, "R5");
            pl(1, 2'd2, W0 + PG1 + 32'(4*k), 32'h80000000 + 32'(k) * 32'h00110011, "R5");
        end
        run();

        // R2: read back through the other alias; window edges
        for (int k = 0; k < 16; k++) begin
            pi(0, 2'd2, W2 + PG1 + 32'(4*k), 32'h0, "R2");
            pl(0, 2'd2, W2 + 32'(4*k),       32'h0, "R2");
        end
        pi(1, 2'd2, 32'h0560FFFC, 32'hFEEDF00D, "R2");
        pi(0, 2'd2, 32'hA560FFFC, 32'h0, "R2");
        pl(1, 2'd2, 32'hA55F0000, 32'h0BADCAFE, "R2");
        pl(0, 2'd2, 32'h055F0000, 32'h0, "R2");
        run();

        // R8: byte and halfword lanes on both pages
        pi(1, 2'd2, W0 + 32'h20, 32'h11223344, "R8");
        pi(1, 2'd0, W0 + 32'h21, 32'hFFFFFFAB, "R8");
        pi(1, 2'd1, W0 + 32'h22, 32'h9999CDEF, "R8");
        pi(0, 2'd2, W0 + 32'h20, 32'h0, "R8");
        pi(0, 2'd0, W0 + 32'h21, 32'h0, "R8");
        pi(0, 2'd1, W0 + 32'h22, 32'h0, "R8");
        pi(0, 2'd0, W0 + 32'h20, 32'h0, "R8");
        pl(1, 2'd2, W0 + PG1 + 32'h40, 32'hA5A5A5A5, "R8");
        pl(1, 2'd0, W0 + PG1 + 32'h43, 32'h0000003C, "R8");
        pl(0, 2'd1, W0 + PG1 + 32'h42, 32'h0, "R8");
        pl(0, 2'd0, W0 + PG1 + 32'h43, 32'h0, "R8");
        pl(0, 2'd1, W2 + PG1 + 32'h40, 32'h0, "R8");
        run();

        // R6: alternating same-page traffic, including write against read
        for (int k = 0; k < 4; k++) pi(0, 2'd2, W0 + 32'(4*k), 32'h0, "R6");
        pl(0, 2'd2, W0 + 32'h10, 32'h0, "R6");
        pl(0, 2'd2, W0 + 32'h14, 32'h0, "R6");
        pi(1, 2'd2, W0 + 32'h30, 32'h5A5A0030, "R6");
        pl(0, 2'd2, W0 + 32'h30, 32'h0, "R6");
        pl(0, 2'd2, W0 + PG1 + 32'h30, 32'h0, "R6");
        for (int k = 0; k < 3; k++) pi(0, 2'd2, W0 + PG1 + 32'(4*k), 32'h0, "R6");
        for (int k = 0; k < 3; k++) pl(1, 2'd2, W0 + PG1 + 32'(4*k+16), 32'h77000000 + 32'(k), "R6");
        run();

        // R4: malformed requests give an error response and write nothing
        pi(1, 2'd1, W0 + 32'h21, 32'h00005555, "R4");
        pi(0, 2'd2, W0 + 32'h02, 32'h0, "R4");
        pi(1, 2'd3, W0 + 32'h20, 32'h66666666, "R4");
        pi(0, 2'd2, W0 + 32'h20, 32'h0, "R4");
        pl(0, 2'd2, W0 + 32'h00, 32'h0, "R4");
        pl(1, 2'd2, W0 + PG1 + 32'h06, 32'h12345678, "R4");
        pl(0, 2'd2, W0 + PG1 + 32'h04, 32'h0, "R4");
        run();

        // R3: misses are dropped without response or write
        pi(1, 2'd2, 32'h255F0010, 32'hDEADBEEF, "R3");
        pi(1, 2'd2, 32'h05610000, 32'hDEADBEEF, "R3");
        pl(1, 2'd2, 32'h055EFFFC, 32'hDEADBEEF, "R3");
        pl(1, 2'd2, 32'hC55F0014, 32'hDEADBEEF, "R3");
        pi(0, 2'd2, W0 + 32'h10, 32'h0, "R3");
        pl(0, 2'd2, W0 + 32'h14, 32'h0, "R3");
        run();

        // R9: offsets a page depth apart share storage; bit 16 still picks the page
        pi(1, 2'd2, W0 + 32'(PB) + 32'h8, 32'h600D0009, "R9");
        pi(0, 2'd2, W0 + 32'h8, 32'h0, "R9");
        pl(0, 2'd2, W0 + PG1 + 32'h8, 32'h0, "R9");
        pl(0, 2'd2, W2 + 32'(2*PB) + 32'h8, 32'h0, "R9");
        run();

        summary();
        $finish;
    end

endmodule